// File: doc/BRIEF.md
# Processor-to-Debugger Byte Mailbox

This block is a one-byte message slot that lets software running on a processor hand bytes to an external debugger. The processor reaches the slot through a simple register-bus port at a single I/O address. A write stores a byte and marks the slot as holding unread data. A read by the processor returns the stored byte, with the unread marker in place of its top bit. The debugger has its own read strobe. Each debugger read takes the slot's contents and clears the marker.

The slot's address is shared with an ordinary I/O register that lives outside this block. The mailbox answers at that address only while the debug-enable fuse input is programmed and the debugger has granted access. In every other case the access is steered to the ordinary register through a pair of pass-through strobes and a read-data input.

A processor write and a debugger read can fall in the same cycle. In that case the marker stays set, so a fresh byte is never reported as already read.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset the stored byte is 0x00 and the unread flag is 0, so `dbg_data` = 0x00 and `dbg_dirty` = 0.
- R2: A processor write (`cpu_wr`=1) to address `MBX_ADDR`, made while the mailbox is selected, stores `cpu_wdata` and sets `dbg_dirty` to 1. Both are visible on the debugger outputs after that clock edge.
- R3: A processor read (`cpu_rd`=1) of `MBX_ADDR` while the mailbox is selected returns, in the same cycle, the stored bits 6..0 in bits 6..0 and the unread flag in bit 7 of `cpu_rdata`.
- R4: A debugger read (`dbg_rd`=1) with no processor write in that cycle clears `dbg_dirty` at the next edge and leaves the stored byte unchanged. A debugger read while the flag is already clear leaves it clear.
- R5: When a selected processor write and a debugger read fall in the same cycle, the new byte is stored and `dbg_dirty` ends at 1.
- R6: A selected write while `dbg_dirty` is already 1 replaces the stored byte and leaves `dbg_dirty` at 1.
- R7: The mailbox is selected only when `fuse_dbg_en`=1 and `dbg_access_en`=1, both sampled in the cycle of the access. Otherwise an access to `MBX_ADDR` raises `io_wr` or `io_rd`, `cpu_rdata` carries `io_rdata`, and the mailbox state does not change.
- R8: An access to any address other than `MBX_ADDR` leaves the mailbox unchanged, keeps `io_wr` and `io_rd` at 0, and drives `cpu_rdata` to 0.
- R9: Changing `fuse_dbg_en` or `dbg_access_en` without an access never changes the stored byte or `dbg_dirty`.
- R10: `dbg_data` presents all 8 stored bits, including bit 7, which is hidden from the processor readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | ADDR_W (6) | Processor I/O address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | DATA_W (8) | Processor write data |
| cpu_rdata | output | DATA_W (8) | Processor read data (combinational) |
| io_wr | output | 1 | Write strobe to the ordinary register at the shared address |
| io_rd | output | 1 | Read strobe to the ordinary register at the shared address |
| io_rdata | input | DATA_W (8) | Read data from the ordinary register |
| fuse_dbg_en | input | 1 | Debug-enable fuse is programmed |
| dbg_access_en | input | 1 | Debugger has enabled mailbox access |
| dbg_rd | input | 1 | Debugger read strobe; clears the unread flag |
| dbg_data | output | DATA_W (8) | Full stored byte for the debugger |
| dbg_dirty | output | 1 | Unread flag |

## Verification
The stored byte and the unread flag each appear directly on debugger outputs, and the flag also appears in bit 7 of the processor readback. A wrong update of either therefore shows at the ports one clock edge after the offending access. A routing fault is visible within the same cycle, as a wrong `io_wr`/`io_rd` strobe or a wrong `cpu_rdata` source. The collision case and the gating-toggle case are driven on purpose, because an error in flag priority or in gating leakage would otherwise go unseen until a later read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_MBX  = 2'd1,
      ROUTE_IO   = 2'd2
   } route_e;
endpackage

// File: rtl/mbx_route.sv
module mbx_route
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned MBX_ADDR    = 'h2A,
   parameter bit          SHARED_ADDR = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              fuse_en,
   input  logic              acc_en,
   output route_e            route
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(MBX_ADDR);

   logic hit;
   logic gate_ok;

   assign hit = (addr == HIT_ADDR);

   generate
      if (SHARED_ADDR) begin : g_gated
         assign gate_ok = fuse_en & acc_en;
      end else begin : g_dedicated
         logic unused_gate;
         assign unused_gate = fuse_en ^ acc_en;
         assign gate_ok     = 1'b1;
      end
   endgenerate

   always_comb begin
      if (!hit)         route = ROUTE_NONE;
      else if (gate_ok) route = ROUTE_MBX;
      else              route = ROUTE_IO;
   end
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_clr,
   output logic [DATA_W-1:0] data_q,
   output logic              dirty_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         dirty_q <= 1'b0;
      end else begin
         if (wr_en) data_q <= wdata;
         if (wr_en)       dirty_q <= 1'b1;
         else if (rd_clr) dirty_q <= 1'b0;
      end
   end

   // R2: a write lands and raises the flag
   a_r2_write_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (dirty_q && data_q == $past(wdata)));

   // R4: a lone debugger read clears the flag and keeps the data
   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !wr_en) |=> (!dirty_q && $stable(data_q)));

   // R5: a write wins over a same-cycle debugger read
   a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && wr_en) |=> dirty_q);

   // R9: with no access the state holds
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_clr && !wr_en) |=> ($stable(data_q) && $stable(dirty_q)));
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned MBX_ADDR    = 'h2A,
   parameter bit          SHARED_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              io_wr,
   output logic              io_rd,
   input  logic [DATA_W-1:0] io_rdata,
   input  logic              fuse_dbg_en,
   input  logic              dbg_access_en,
   input  logic              dbg_rd,
   output logic [DATA_W-1:0] dbg_data,
   output logic              dbg_dirty
);
   localparam int unsigned FLAG_BIT = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dbg_mailbox: DATA_W must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("dbg_mailbox: ADDR_W must be 1..16");
      end
      if (MBX_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("dbg_mailbox: MBX_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   route_e            route;
   logic              mbx_wr;
   logic [DATA_W-1:0] store_q;
   logic              dirty_q;
   logic [DATA_W-1:0] fold_rd;

   mbx_route #(
      .ADDR_W      (ADDR_W),
      .MBX_ADDR    (MBX_ADDR),
      .SHARED_ADDR (SHARED_ADDR)
   ) u_route (
      .addr    (cpu_addr),
      .fuse_en (fuse_dbg_en),
      .acc_en  (dbg_access_en),
      .route   (route)
   );

   assign mbx_wr = cpu_wr && (route == ROUTE_MBX);
   assign io_wr  = cpu_wr && (route == ROUTE_IO);
   assign io_rd  = cpu_rd && (route == ROUTE_IO);

   mbx_cell #(
      .DATA_W (DATA_W)
   ) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mbx_wr),
      .wdata   (cpu_wdata),
      .rd_clr  (dbg_rd),
      .data_q  (store_q),
      .dirty_q (dirty_q)
   );

   assign fold_rd = {dirty_q, store_q[FLAG_BIT-1:0]};

   always_comb begin
      cpu_rdata = '0;
      if (cpu_rd) begin
         case (route)
            ROUTE_MBX: cpu_rdata = fold_rd;
            ROUTE_IO:  cpu_rdata = io_rdata;
            default:   cpu_rdata = '0;
         endcase
      end
   end

   assign dbg_data  = store_q;
   assign dbg_dirty = dirty_q;

   // R8: other addresses raise no strobe at all
   a_r8_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr != ADDR_W'(MBX_ADDR)) |-> (!io_wr && !io_rd && !mbx_wr));

   // R8: foreign accesses leave the mailbox as it was
   a_r8_foreign_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr != ADDR_W'(MBX_ADDR) && !dbg_rd) |=> ($stable(dbg_data) && $stable(dbg_dirty)));

   // R7: never both destinations in one write
   a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && mbx_wr));

   generate
      if (SHARED_ADDR) begin : g_gate_chk
         // R7: ungated write at the shared address goes to the ordinary register
         a_r7_ungated_io: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr && cpu_addr == ADDR_W'(MBX_ADDR) && !(fuse_dbg_en && dbg_access_en))
               |-> (io_wr && !mbx_wr));
         // R7: ungated write leaves the stored byte alone
         a_r7_ungated_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr && !(fuse_dbg_en && dbg_access_en)) |=> $stable(dbg_data));
      end
   endgenerate
endmodule

// File: tb/dbg_mailbox_bench.sv
module dbg_mailbox_bench;
   localparam int unsigned DW = 8;
   localparam int unsigned AW = 6;
   localparam logic [AW-1:0] MA = 6'h2A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_wr = 1'b0;
   logic          cpu_rd = 1'b0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          io_wr;
   logic          io_rd;
   logic [DW-1:0] io_rdata = '0;
   logic          fuse_dbg_en = 1'b1;
   logic          dbg_access_en = 1'b1;
   logic          dbg_rd = 1'b0;
   logic [DW-1:0] dbg_data;
   logic          dbg_dirty;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dbg_mailbox #(.DATA_W(DW), .ADDR_W(AW), .MBX_ADDR('h2A), .SHARED_ADDR(1'b1)) u_dbg_mailbox (
      .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wr (cpu_wr), .cpu_rd (cpu_rd),
      .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata), .io_wr (io_wr), .io_rd (io_rd),
      .io_rdata (io_rdata), .fuse_dbg_en (fuse_dbg_en), .dbg_access_en (dbg_access_en),
      .dbg_rd (dbg_rd), .dbg_data (dbg_data), .dbg_dirty (dbg_dirty)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // write during one cycle, optionally with a debugger read alongside
   task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit with_dbg);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; dbg_rd = with_dbg;
      tick();
      cpu_wr = 1'b0; dbg_rd = 1'b0;
   endtask

   task automatic cpu_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      cpu_addr = a; cpu_rd = 1'b1;
      #2;
      d = cpu_rdata;
      cpu_rd = 1'b0;
   endtask

   task automatic dbg_read();
      dbg_rd = 1'b1;
      tick();
      dbg_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [DW-1:0] r;
      check("R1 data", dbg_data, 8'h00);
      check("R1 dirty", dbg_dirty, 0);
      cpu_read(MA, r);
      check("R1 readback", r, 8'h00);
   endtask

   task automatic t_write();
      logic [DW-1:0] r;
      cpu_write(MA, 8'hA5, 1'b0);
      check("R2 data", dbg_data, 8'hA5);
      check("R2 dirty", dbg_dirty, 1);
      cpu_read(MA, r);
      check("R3 fold A5", r, 8'hA5);
      cpu_write(MA, 8'h3C, 1'b0);
      check("R6 data", dbg_data, 8'h3C);
      check("R6 dirty", dbg_dirty, 1);
      cpu_read(MA, r);
      check("R3 fold 3C dirty", r, 8'hBC);
   endtask

   task automatic t_dbg_read();
      logic [DW-1:0] r;
      dbg_read();
      check("R4 dirty cleared", dbg_dirty, 0);
      check("R4 data kept", dbg_data, 8'h3C);
      cpu_read(MA, r);
      check("R3 fold clean", r, 8'h3C);
      dbg_read();
      check("R4 stays clear", dbg_dirty, 0);
      cpu_write(MA, 8'hFF, 1'b0);
      dbg_read();
      check("R10 full byte", dbg_data, 8'hFF);
      cpu_read(MA, r);
      check("R3 bit7 hidden", r, 8'h7F);
   endtask

   task automatic t_collide();
      cpu_write(MA, 8'h11, 1'b1);
      check("R5 data", dbg_data, 8'h11);
      check("R5 dirty", dbg_dirty, 1);
   endtask

   task automatic t_ungated(input bit f, input bit e);
      logic [DW-1:0] r;
      fuse_dbg_en = f; dbg_access_en = e; io_rdata = 8'h42;
      cpu_addr = MA; cpu_wdata = 8'h99; cpu_wr = 1'b1;
      #2;
      check("R7 io_wr", io_wr, 1);
      tick();
      cpu_wr = 1'b0;
      check("R7 data held", dbg_data, 8'h11);
      check("R7 dirty held", dbg_dirty, 1);
      cpu_addr = MA; cpu_rd = 1'b1;
      #2;
      check("R7 io_rd", io_rd, 1);
      r = cpu_rdata;
      cpu_rd = 1'b0;
      check("R7 io readback", r, 8'h42);
      tick();
      fuse_dbg_en = 1'b1; dbg_access_en = 1'b1;
   endtask

   task automatic t_other_addr();
      logic [DW-1:0] r;
      cpu_addr = MA + 6'd1; cpu_wdata = 8'h5A; cpu_wr = 1'b1;
      #2;
      check("R8 no io_wr", io_wr, 0);
      tick();
      cpu_wr = 1'b0;
      check("R8 data held", dbg_data, 8'h11);
      check("R8 dirty held", dbg_dirty, 1);
      cpu_read(MA - 6'd1, r);
      check("R8 readback zero", r, 8'h00);
      check("R8 no io_rd", io_rd, 0);
   endtask

   task automatic t_gate_toggle();
      for (int i = 0; i < 6; i++) begin
         fuse_dbg_en = i[0]; dbg_access_en = i[1];
         tick();
      end
      check("R9 data held", dbg_data, 8'h11);
      check("R9 dirty held", dbg_dirty, 1);
      fuse_dbg_en = 1'b1; dbg_access_en = 1'b1;
      tick();
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_write();
      t_dbg_read();
      t_collide();
      t_ungated(1'b0, 1'b1);
      t_ungated(1'b1, 1'b0);
      t_other_addr();
      t_gate_toggle();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule